// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a register-mapped bank of independent down-counting timers. The default build has four channels of 32 bits each. Each channel owns a 16-byte window that holds a reload value, a read-only live count, a control word and a sticky expiry flag. A single module control register at the bottom of the map can freeze every channel at once.

A running channel counts down once per clock. When it is at zero and would step again, it raises its flag and reloads from its reload register, so it fires every load+1 cycles. A new reload value written while the channel runs is used only at the next reload. Toggling the enable bit off and on restarts the count at once. Any channel other than channel 0 can be linked to its lower neighbour. It then steps only when that neighbour expires, so two adjacent channels act as one 64-bit counter.

Software uses a simple synchronous bus. A write takes effect on the clock edge where select and write are both high. Read data is combinational and is valid while select is high and write is low. Each channel drives its own level interrupt.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the module control register reads 0x2 (all channels frozen), every channel register reads 0 and every interrupt output is low.
- R2: Address map: the module control register is at byte offset 0x000. Channel n occupies 0x100+0x10*n. Within a channel window, reload is at +0x0, live count at +0x4, control at +0x8 and flag at +0xC. Control bit 0 is run, bit 1 is interrupt enable and bit 2 is link. Reload, control and module control read back what was written.
- R3: The cycle after the run bit goes from 0 to 1, the count takes the reload value L. After that it steps down by one per cycle and returns to L on the step after reaching 0. The count seen k cycles after the enabling write edge is L-((k-1) mod (L+1)), for k of 1 or more.
- R4: Flag bit 0 is set on the step that leaves zero. The first such step is k=L+2 cycles after the enabling write edge. Writing 1 to flag bit 0 clears it. Writing 0 leaves it unchanged.
- R5: A channel's interrupt output is high exactly when its flag and its interrupt-enable bit are both 1. It stays high until the flag is cleared or interrupt enable is cleared.
- R6: A reload value written while the channel runs does not disturb the current count and is taken at the next reload. Clearing and then setting run restarts the count from the newest reload value.
- R7: While run is 0, the count holds its value and the flag is never set.
- R8: While module control bit 1 is 1, no channel steps. Clearing it resumes every running channel from where it stopped, and the first step comes one cycle after the write edge.
- R9: A channel n>0 whose link bit is set steps once for each expiry of channel n-1, and otherwise holds.
- R10: The link bit of channel 0 reads back but has no effect: channel 0 still steps every cycle.
- R11: Reads of unmapped or misaligned offsets return 0. Writes to a live count register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational, 0 when not reading |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
The bench sweeps reload values 0 to 7 across all channels and compares every live count and flag against the closed-form period formula. An off-by-one in the reload path or a missing enable-load cycle therefore shows up as a shifted sequence. L=0 is the sharpest case: a design that expires only on a 1-to-0 transition would never raise the flag. A reload value written mid-count is checked at the exact reload cycle, and a design that restarts on the write would show the new value early. Linked counting is checked against the expiry count of the lower channel, which catches a design that steps every cycle or misses the reload step of the linked channel. Freeze, stop, interrupt-enable masking, write-one-to-clear and ignored count writes are each checked at the ports across several idle cycles.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Register map
  localparam int unsigned MCR_ADDR = 'h000;
  localparam int unsigned WIN_BASE = 'h100;
  localparam int unsigned WIN_SPAN = 'h10;

  // Field positions
  localparam int unsigned HALT_BIT = 1;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned IRQ_BIT  = 1;
  localparam int unsigned LINK_BIT = 2;
  localparam int unsigned CLR_BIT  = 0;

  typedef enum logic [1:0] {
    SLOT_LOAD  = 2'd0,
    SLOT_COUNT = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_FLAG  = 2'd3
  } slot_e;

  typedef struct packed {
    logic link;
    logic irq_en;
    logic run;
  } chan_ctrl_t;

endpackage

// File: rtl/tick_timer_rst_sync.sv
module tick_timer_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
  import tick_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mcr_hit_o,
  output logic [NUM_CH-1:0] ch_hit_o,
  output slot_e             slot_o
);

  localparam int unsigned WIN_SHIFT = $clog2(WIN_SPAN);
  localparam int unsigned PAGE_W    = ADDR_W - WIN_SHIFT;

  logic aligned;

  always_comb begin
    aligned   = (addr_i[1:0] == 2'b00);
    mcr_hit_o = (addr_i == ADDR_W'(MCR_ADDR));
    slot_o    = slot_e'(addr_i[WIN_SHIFT-1:2]);
    for (int i = 0; i < NUM_CH; i++) begin
      ch_hit_o[i] = aligned &&
                    (addr_i[ADDR_W-1:WIN_SHIFT] == PAGE_W'(WIN_BASE / WIN_SPAN + i));
    end
  end

endmodule

// File: rtl/tick_timer_modctl.sv
module tick_timer_modctl
  import tick_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic halt_bit_i,
  output logic halt_o
);

  logic halt_q;
  logic halt_d;
  logic halt_en;

  always_comb begin
    halt_en = wr_i;
    halt_d  = halt_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
    end else if (halt_en) begin
      halt_q <= halt_d;
    end
  end

  assign halt_o = halt_q;

  // R8
  halt_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (halt_o == $past(halt_bit_i)));

endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  logic             step_ok_i,
  input  logic             wr_load_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_flag_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] count_o,
  output chan_ctrl_t       ctrl_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count_q, count_d;
  chan_ctrl_t       ctrl_q, ctrl_d;
  logic             flag_q, flag_d;
  logic             run_prev_q;
  logic             run_rise, at_zero, tick, expire;
  logic             count_en, flag_en;

  always_comb begin
    run_rise = ctrl_q.run & ~run_prev_q;
    at_zero  = (count_q == '0);
    tick     = ctrl_q.run & ~halt_i & ~run_rise & step_ok_i;
    expire   = tick & at_zero;
    count_en = run_rise | tick;
    if (run_rise || at_zero) begin
      count_d = load_q;
    end else begin
      count_d = count_q - CNT_W'(1);
    end
    // an expiry in the same cycle as a clear keeps the flag set
    flag_en = expire | (wr_flag_i & wdata_i[CLR_BIT]);
    flag_d  = expire;
    ctrl_d  = '{link: wdata_i[LINK_BIT], irq_en: wdata_i[IRQ_BIT], run: wdata_i[RUN_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q     <= '0;
      count_q    <= '0;
      ctrl_q     <= '0;
      flag_q     <= 1'b0;
      run_prev_q <= 1'b0;
    end else begin
      run_prev_q <= ctrl_q.run;
      if (wr_load_i) load_q  <= wdata_i;
      if (count_en)  count_q <= count_d;
      if (wr_ctrl_i) ctrl_q  <= ctrl_d;
      if (flag_en)   flag_q  <= flag_d;
    end
  end

  assign load_o   = load_q;
  assign count_o  = count_q;
  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ctrl_q.irq_en;
  assign expire_o = expire;

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |=> $stable(count_q));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !run_rise) |=> $stable(count_q));

  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == $past(load_q)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_zero) |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire));

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(wr_flag_i && wdata_i[CLR_BIT]) && !wr_ctrl_i) |=> irq_o);

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  logic              rst_n_s;
  logic              mcr_hit;
  logic [NUM_CH-1:0] ch_hit;
  slot_e             slot;
  logic              wr_en, rd_en;
  logic              halt;

  logic [CNT_W-1:0]  load_arr  [NUM_CH];
  logic [CNT_W-1:0]  count_arr [NUM_CH];
  chan_ctrl_t        ctrl_arr  [NUM_CH];
  logic [NUM_CH-1:0] flag_vec;

  assign wr_en = bus_sel &  bus_we;
  assign rd_en = bus_sel & ~bus_we;

  tick_timer_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  tick_timer_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .addr_i    (bus_addr),
    .mcr_hit_o (mcr_hit),
    .ch_hit_o  (ch_hit),
    .slot_o    (slot)
  );

  tick_timer_modctl u_modctl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_i       (wr_en & mcr_hit),
    .halt_bit_i (bus_wdata[HALT_BIT]),
    .halt_o     (halt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic step_ok;
    logic expire_w;
    logic sel_w;

    assign sel_w = wr_en & ch_hit[g];

    if (g == 0) begin : g_head
      assign step_ok = 1'b1;
    end else begin : g_link
      assign step_ok = ~ctrl_arr[g].link | g_ch[g-1].expire_w;
    end

    tick_timer_chan #(
      .CNT_W (CNT_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .halt_i    (halt),
      .step_ok_i (step_ok),
      .wr_load_i (sel_w & (slot == SLOT_LOAD)),
      .wr_ctrl_i (sel_w & (slot == SLOT_CTRL)),
      .wr_flag_i (sel_w & (slot == SLOT_FLAG)),
      .wdata_i   (bus_wdata),
      .load_o    (load_arr[g]),
      .count_o   (count_arr[g]),
      .ctrl_o    (ctrl_arr[g]),
      .flag_o    (flag_vec[g]),
      .irq_o     (irq[g]),
      .expire_o  (expire_w)
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (mcr_hit) begin
        bus_rdata[HALT_BIT] = halt;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_hit[i]) begin
          unique case (slot)
            SLOT_LOAD:  bus_rdata = load_arr[i];
            SLOT_COUNT: bus_rdata = count_arr[i];
            SLOT_CTRL:  bus_rdata = CNT_W'(ctrl_arr[i]);
            SLOT_FLAG:  bus_rdata = CNT_W'(flag_vec[i]);
            default:    bus_rdata = '0;
          endcase
        end
      end
    end
  end

  // R2
  window_unique_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({mcr_hit, ch_hit}));

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |-> (bus_rdata == '0));

endmodule

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;

  localparam int NUM_CH = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks;
  int failures;
  int cyc;
  bit done;

  tick_timer_bank u_tick_timer_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] ra(input int ch, input int slot);
    return 12'('h100 + 16 * ch + 4 * slot);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_sel   = 1'b1;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    bus_sel  = 1'b1;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    int cyc_en;
    int n;
    int e;
    int c0;

    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(12'h000, v); check("R1 module control", v, 32'h2);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int s = 0; s < 4; s++) begin
        rd(ra(ch, s), v); check("R1 channel register", v, 32'h0);
      end
    end
    check("R1 irq", 32'(irq), 32'h0);

    // R2 map and readback
    wr(12'h000, 32'h0);
    rd(12'h000, v); check("R2 module control readback", v, 32'h0);
    wr(ra(2, 2), 32'h6);
    rd(ra(2, 2), v); check("R2 control readback", v, 32'h6);
    wr(ra(2, 2), 32'h0);

    // R3 / R4 sweep over reload values
    for (int L = 0; L < 8; L++) begin
      int ch;
      ch = L % NUM_CH;
      wr(ra(ch, 2), 32'h0);
      wr(ra(ch, 3), 32'h1);
      wr(ra(ch, 0), 32'(L));
      rd(ra(ch, 0), v); check("R2 reload readback", v, 32'(L));
      wr(ra(ch, 2), 32'h1);
      cyc_en = cyc;
      for (int k = 0; k < 2 * (L + 1) + 3; k++) begin
        step();
        n = cyc - cyc_en;
        rd(ra(ch, 1), v); check("R3 count sequence", v, 32'(L - ((n - 1) % (L + 1))));
        rd(ra(ch, 3), v); check("R4 flag timing", v, (n >= L + 2) ? 32'h1 : 32'h0);
      end
      check("R5 no irq without enable", 32'(irq), 32'h0);
      wr(ra(ch, 2), 32'h0);
      wr(ra(ch, 3), 32'h1);
      rd(ra(ch, 3), v); check("R4 write one clears", v, 32'h0);
    end

    // R5 interrupt behaviour
    wr(ra(1, 0), 32'd3);
    wr(ra(1, 2), 32'h3);
    cyc_en = cyc;
    repeat (4) step();
    check("R5 irq before expiry", 32'(irq), 32'h0);
    step();
    check("R5 irq at expiry", 32'(irq), 32'h2);
    wr(ra(1, 3), 32'h0);
    rd(ra(1, 3), v); check("R4 write zero keeps flag", v, 32'h1);
    check("R5 irq held", 32'(irq), 32'h2);
    wr(ra(1, 2), 32'h1);
    check("R5 irq masked", 32'(irq), 32'h0);
    rd(ra(1, 3), v); check("R5 flag kept while masked", v, 32'h1);
    wr(ra(1, 2), 32'h3);
    check("R5 irq unmasked", 32'(irq), 32'h2);
    wr(ra(1, 2), 32'h2);
    wr(ra(1, 3), 32'h1);
    check("R5 irq after clear", 32'(irq), 32'h0);

    // R7 stopped channel holds
    rd(ra(1, 1), v);
    repeat (10) step();
    rd(ra(1, 1), v2); check("R7 count held", v2, v);
    rd(ra(1, 3), v2); check("R7 no flag while stopped", v2, 32'h0);

    // R6 reload written mid-count
    wr(ra(3, 0), 32'd5);
    wr(ra(3, 2), 32'h1);
    cyc_en = cyc;
    repeat (3) step();
    wr(ra(3, 0), 32'd2);
    for (int k = 0; k < 8; k++) begin
      step();
      n = cyc - cyc_en;
      rd(ra(3, 1), v);
      if (n <= 6) check("R6 old period continues", v, 32'(5 - (n - 1)));
      else        check("R6 new reload used", v, 32'(2 - ((n - 7) % 3)));
    end
    wr(ra(3, 0), 32'd6);
    wr(ra(3, 2), 32'h0);
    wr(ra(3, 2), 32'h1);
    step();
    rd(ra(3, 1), v); check("R6 restart loads newest", v, 32'd6);

    // R8 module freeze
    wr(ra(0, 3), 32'h1);
    wr(ra(0, 0), 32'd9);
    wr(ra(0, 2), 32'h1);
    repeat (2) step();
    wr(12'h000, 32'h2);
    rd(ra(0, 1), v); check("R8 count at freeze", v, 32'd7);
    rd(ra(3, 1), v2);
    repeat (6) step();
    rd(ra(0, 1), v); check("R8 channel 0 frozen", v, 32'd7);
    rd(ra(3, 1), v); check("R8 channel 3 frozen", v, v2);
    wr(12'h000, 32'h0);
    step();
    rd(ra(0, 1), v); check("R8 resume", v, 32'd6);

    // R9 linked pair
    wr(ra(0, 2), 32'h0);
    wr(ra(0, 3), 32'h1);
    wr(ra(1, 3), 32'h1);
    wr(ra(0, 0), 32'd2);
    wr(ra(1, 0), 32'd3);
    wr(ra(1, 2), 32'h5);
    repeat (3) step();
    rd(ra(1, 1), v); check("R9 linked holds without source", v, 32'd3);
    wr(ra(0, 2), 32'h1);
    cyc_en = cyc;
    for (int k = 0; k < 40; k++) begin
      step();
      n = cyc - cyc_en;
      e = (n - 1) / 3;
      rd(ra(1, 1), v); check("R9 linked count", v, 32'(3 - (e % 4)));
      rd(ra(1, 3), v); check("R9 linked flag", v, (e >= 4) ? 32'h1 : 32'h0);
    end
    wr(ra(1, 2), 32'h0);

    // R10 link bit of channel 0 has no effect
    wr(ra(0, 2), 32'h0);
    wr(ra(0, 2), 32'h5);
    cyc_en = cyc;
    rd(ra(0, 2), v); check("R10 link bit readback", v, 32'h5);
    for (int k = 0; k < 8; k++) begin
      step();
      n = cyc - cyc_en;
      rd(ra(0, 1), v); check("R10 channel 0 free running", v, 32'(2 - ((n - 1) % 3)));
    end

    // R11 unmapped reads and ignored count writes
    rd(12'h004, v); check("R11 unmapped 0x004", v, 32'h0);
    rd(12'h140, v); check("R11 unmapped 0x140", v, 32'h0);
    rd(12'h101, v); check("R11 misaligned", v, 32'h0);
    wr(ra(0, 1), 32'hDEADBEEF);
    n = cyc - cyc_en;
    rd(ra(0, 1), v); check("R11 count write ignored", v, 32'(2 - ((n - 1) % 3)));
    step();
    n = cyc - cyc_en;
    rd(ra(0, 1), v); check("R11 count still running", v, 32'(2 - ((n - 1) % 3)));

    done = 1'b1;
    summary();
  end

endmodule